// File: doc/BRIEF.md
# Graphics Command Packet Framer

This block sits on the graphics command port and turns a plain stream of 32-bit words into whole command packets. The top byte of the first word of each packet is the opcode. A length rule computed from the opcode gives the number of parameter words that follow. Once the last word of a packet has arrived, the block presents the whole packet in parallel for one cycle. Words may arrive with any gaps between them. A partly received packet is held in a small buffer until the rest arrives.

Some opcodes are handled inside the block. Environment opcodes (0xE0 to 0xE7) are not passed on as packets: each one is stored in one of eight shadow registers, and two of those registers drive the low bits of a status word. Polylines have no fixed length, so a terminator word closes them. An image-upload header switches the input over to a pixel port until the announced number of pixel words has passed through.

A synchronous control pulse returns the block to its idle state without a full reset.

Top module: `cmd_packet_framer`

## Requirements
- R1: A non-polyline packet is emitted once 1 + N words have been accepted, where N is the parameter count for its opcode. For polygons (0x20-0x3F), N = V*(1 + op[2] + op[4]) - op[4], with V = 4 if op[3] is set and 3 otherwise. For lines (0x40-0x5F), N = 2 + op[4] + op[3]. For rectangles (0x60-0x7F), N = 1 + op[2], plus 1 more when op[4:3] = 00. N = 2 for 0x02, 3 for 0x80-0x9F and 2 for 0xA0-0xDF. Every other opcode below 0xE0 has N = 0.
- R2: A polyline opcode (0x40-0x5F with bit 3 set) stays open until a word w with (w & 0xF000F000) == 0x50005000 arrives at word index 3 or later. When op[4] is set, only even indices from 4 upward are checked. Index 0 is the opcode word, and the terminator is included in the packet. A polyline that reaches DEPTH (16) words without a terminator is closed there.
- R3: A word whose opcode is 0xE0-0xE7 is written whole into environment register (opcode & 7) and produces no packet. Register i appears on env_regs[32*i+31:32*i].
- R4: status[10:0] equals bits 10:0 of register 1, and status[12:11] equals bits 1:0 of register 6, starting the cycle after the write.
- R5: After an upload header (0xA0-0xBF) has been emitted as a 3-word packet, the next ceil(W*H/2) input words skip framing. Each of them appears on pix_word with pix_valid high one cycle after it is accepted. W comes from header word 2 bits 9:0 (0 means 1024) and H from bits 24:16 (0 means 512). A 0xC0-0xDF header is emitted with no pixel phase.
- R6: status[13] is high from the cycle after the upload header completes until the cycle after its last pixel word.
- R7: A partial packet survives any number of idle cycles and completes when its remaining words arrive. status[14] is high while a partial packet is held.
- R8: Reset (rst_n low) or a ctl_reset pulse loads register i with (0xE0+i)<<24, discards any partial packet, cancels any upload, and leaves status at 0.
- R9: pkt_valid is high for the single cycle after the last word of a packet is accepted. pkt_count gives the packet length, and word k is on pkt_words[32*k+31:32*k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_reset | input | 1 | Synchronous pulse that returns the block to idle |
| in_valid | input | 1 | Input word present this cycle |
| in_word | input | 32 | Input command or pixel word |
| pkt_valid | output | 1 | Complete packet on pkt_words for this cycle |
| pkt_count | output | 5 | Number of valid words in the packet |
| pkt_words | output | 512 | Packet words, word k at bits 32k+31:32k |
| pix_valid | output | 1 | Pixel word present on pix_word |
| pix_word | output | 32 | Forwarded pixel data word |
| env_regs | output | 256 | Eight environment registers, register i at bits 32i+31:32i |
| status | output | 15 | {partial held, upload active, E6[1:0], E1[10:0]} |

## Verification
If the word counter or the stored opcode is wrong, the error shows on the next packet. pkt_valid then rises a word early or late, or pkt_count is off. The checks therefore watch pkt_valid after every word, not only after the last one. A wrong pixel counter leaves status[13] stuck high or clears it early, and the next command word then either appears on the pixel port or is framed when it should not be. Both show within one word of the expected boundary. A lost environment write shows up in status bits one cycle after the write.

// File: rtl/pktfr_pkg.sv
`timescale 1ns/1ps
// pktfr_pkg: shared constants and the opcode-to-parameter-count rule.
// Assumes the opcode is the top byte of the first word of a packet.
package pktfr_pkg;
    localparam int WORD_W = 32;
    localparam logic [31:0] TERM_MASK = 32'hF000F000;
    localparam logic [31:0] TERM_CODE = 32'h50005000;

    // Number of words that follow the opcode word, derived from opcode bit fields
    function automatic logic [3:0] param_words(input logic [7:0] op);
        logic [3:0] verts;
        logic [3:0] mult;
        logic [3:0] n;
        verts = op[3] ? 4'd4 : 4'd3;
        mult  = 4'd1 + {3'b000, op[2]} + {3'b000, op[4]};
        n     = 4'd0;
        if (op == 8'h02) begin
            n = 4'd2;
        end else begin
            case (op[7:5])
                3'b001:        n = verts * mult - {3'b000, op[4]};
                3'b010:        n = 4'd2 + {3'b000, op[4]} + {3'b000, op[3]};
                3'b011:        n = 4'd1 + {3'b000, op[2]} + {3'b000, (op[4:3] == 2'b00)};
                3'b100:        n = 4'd3;
                3'b101, 3'b110: n = 4'd2;
                default:       n = 4'd0;
            endcase
        end
        return n;
    endfunction
endpackage

// File: rtl/pktfr_env.sv
`timescale 1ns/1ps
// pktfr_env: bank of eight environment shadow registers and the status
// bits derived from them. Assumes at most one write per cycle.
module pktfr_env (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         we,
    input  logic [2:0]   idx,
    input  logic [31:0]  data,
    output logic [255:0] env_flat,
    output logic [12:0]  env_status
);
    localparam int NREG = 8;

    logic [31:0] regs [NREG];

    // Reload or update each register; the reload value carries its own opcode
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                regs[i] <= {8'hE0 + 8'(i), 24'h000000};
            else if (we && idx == 3'(i))
                regs[i] <= data;
        end
        assign env_flat[32*i +: 32] = regs[i];
    end

    // Status view: drawing-mode bits of register 1, mask bits of register 6
    assign env_status = {regs[6][1:0], regs[1][10:0]};

    AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> env_status == 13'd0); // R8
    AST_MODE_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == 3'd1 && !clr) |=> env_status[10:0] == $past(data[10:0])); // R4
endmodule

// File: rtl/pktfr_xfer.sv
`timescale 1ns/1ps
// pktfr_xfer: counts pixel words of an image upload and forwards them.
// Assumes go is only raised while no upload is running.
module pktfr_xfer #(
    parameter int XW = 10,
    parameter int YW = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        go,
    input  logic [31:0] size_word,
    input  logic        word_valid,
    input  logic [31:0] in_word,
    output logic        active,
    output logic        pix_valid,
    output logic [31:0] pix_word
);
    localparam int PW = XW + YW + 2;

    logic [XW-1:0] w_m1;
    logic [YW-1:0] h_m1;
    logic [PW-1:0] pixels;
    logic [PW-1:0] words;
    logic [PW-1:0] rem;

    // Dimensions with a zero field meaning the full range, then words = ceil(pixels/2)
    always_comb begin
        w_m1   = size_word[XW-1:0] - 1'b1;
        h_m1   = size_word[16 +: YW] - 1'b1;
        pixels = PW'({1'b0, w_m1} + 1'b1) * PW'({1'b0, h_m1} + 1'b1);
        words  = (pixels + 1'b1) >> 1;
    end

    assign active = (rem != '0);

    // Load the word budget on a header, then forward and count down
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rem       <= '0;
            pix_valid <= 1'b0;
            pix_word  <= '0;
        end else begin
            pix_valid <= 1'b0;
            if (go) begin
                rem <= words;
            end else if (word_valid && active) begin
                rem       <= rem - 1'b1;
                pix_valid <= 1'b1;
                pix_word  <= in_word;
            end
        end
    end

    AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !active); // R5
    AST_PIX_NEEDS_UPLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(active)); // R6
endmodule

// File: rtl/pktfr_asm.sv
`timescale 1ns/1ps
// pktfr_asm: collects command words into a packet buffer and decides when
// a packet is complete. Assumes DEPTH >= 12 so every fixed-length packet fits.
module pktfr_asm
    import pktfr_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  in_fire,
    input  logic [31:0]           in_word,
    output logic                  pkt_valid,
    output logic [CW-1:0]         pkt_count,
    output logic [DEPTH*32-1:0]   pkt_words,
    output logic                  env_we,
    output logic                  up_go,
    output logic                  held
);
    logic [31:0]   slots [DEPTH];
    logic [CW-1:0] count;
    logic [CW-1:0] need_q;
    logic [7:0]    op_q;
    logic          poly_q;
    logic          shaded_q;
    logic          first;
    logic          is_env;
    logic          term_hit;
    logic          done;

    // Completion decision for the word being accepted this cycle
    always_comb begin
        first    = (count == '0);
        is_env   = first && (in_word[31:27] == 5'b11100);
        term_hit = (in_word & TERM_MASK) == TERM_CODE;
        if (first)
            done = (param_words(in_word[31:24]) == 4'd0);
        else if (poly_q)
            done = (count == CW'(DEPTH - 1)) ||
                   (term_hit && (shaded_q ? (count >= CW'(4) && !count[0])
                                          : (count >= CW'(3))));
        else
            done = (count + 1'b1 == need_q);
    end

    assign env_we = in_fire && is_env;
    assign up_go  = in_fire && !first && done && (op_q[7:5] == 3'b101);
    assign held   = (count != '0);

    // Framing state: word count, opcode attributes and the emit strobe
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count     <= '0;
            need_q    <= '0;
            op_q      <= '0;
            poly_q    <= 1'b0;
            shaded_q  <= 1'b0;
            pkt_valid <= 1'b0;
            pkt_count <= '0;
        end else begin
            pkt_valid <= 1'b0;
            if (in_fire && !is_env) begin
                if (done) begin
                    count     <= '0;
                    pkt_valid <= 1'b1;
                    pkt_count <= count + 1'b1;
                end else begin
                    count <= count + 1'b1;
                end
                if (first) begin
                    op_q     <= in_word[31:24];
                    need_q   <= CW'(param_words(in_word[31:24])) + 1'b1;
                    poly_q   <= (in_word[31:29] == 3'b010) && in_word[27];
                    shaded_q <= in_word[28];
                end
            end
        end
    end

    // Packet storage; stays stable during the pkt_valid cycle, no reset needed
    always_ff @(posedge clk) begin
        if (in_fire && !is_env)
            slots[count[IW-1:0]] <= in_word;
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_out
        assign pkt_words[32*k +: 32] = slots[k];
    end

    AST_HELD_BELOW_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        count < CW'(DEPTH)); // R2
    AST_PKT_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_count != '0 && pkt_count <= CW'(DEPTH))); // R9
    AST_ENV_NOT_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> slots[0][31:27] != 5'b11100); // R3
endmodule

// File: rtl/cmd_packet_framer.sv
`timescale 1ns/1ps
// cmd_packet_framer: groups command-port words into packets, absorbs
// environment words and steers image-upload pixel words to their own port.
// Assumes in_word is sampled whenever in_valid is high (no back-pressure).
module cmd_packet_framer #(
    parameter int DEPTH = 16,
    parameter int XW    = 10,
    parameter int YW    = 9,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_reset,
    input  logic                 in_valid,
    input  logic [31:0]          in_word,
    output logic                 pkt_valid,
    output logic [CW-1:0]        pkt_count,
    output logic [DEPTH*32-1:0]  pkt_words,
    output logic                 pix_valid,
    output logic [31:0]          pix_word,
    output logic [255:0]         env_regs,
    output logic [14:0]          status
);
    logic        up_active;
    logic        in_fire;
    logic        env_we;
    logic        up_go;
    logic        held;
    logic [12:0] env_status;

    // Words go to the framer only while no upload owns the input
    assign in_fire = in_valid && !up_active;

    pktfr_asm #(.DEPTH(DEPTH)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ctl_reset),
        .in_fire   (in_fire),
        .in_word   (in_word),
        .pkt_valid (pkt_valid),
        .pkt_count (pkt_count),
        .pkt_words (pkt_words),
        .env_we    (env_we),
        .up_go     (up_go),
        .held      (held)
    );

    pktfr_env u_env (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (ctl_reset),
        .we         (env_we),
        .idx        (in_word[26:24]),
        .data       (in_word),
        .env_flat   (env_regs),
        .env_status (env_status)
    );

    pktfr_xfer #(.XW(XW), .YW(YW)) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (ctl_reset),
        .go         (up_go),
        .size_word  (in_word),
        .word_valid (in_valid),
        .in_word    (in_word),
        .active     (up_active),
        .pix_valid  (pix_valid),
        .pix_word   (pix_word)
    );

    assign status = {held, up_active, env_status};

    AST_NO_PKT_DURING_PIX: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> !pkt_valid); // R5
endmodule

// File: tb/cmd_packet_framer_bench.sv
`timescale 1ns/1ps
module cmd_packet_framer_bench;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_reset = 1'b0;
    logic          in_valid = 1'b0;
    logic [31:0]   in_word = '0;
    logic          pkt_valid;
    logic [4:0]    pkt_count;
    logic [511:0]  pkt_words;
    logic          pix_valid;
    logic [31:0]   pix_word;
    logic [255:0]  env_regs;
    logic [14:0]   status;

    int n_cmp = 0;
    int n_bad = 0;

    cmd_packet_framer u_cmd_packet_framer (
        .clk(clk), .rst_n(rst_n), .ctl_reset(ctl_reset),
        .in_valid(in_valid), .in_word(in_word),
        .pkt_valid(pkt_valid), .pkt_count(pkt_count), .pkt_words(pkt_words),
        .pix_valid(pix_valid), .pix_word(pix_word),
        .env_regs(env_regs), .status(status)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One word, then an idle cycle; returns at a falling edge after the capture edge
    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_ctl();
        @(negedge clk);
        ctl_reset = 1'b1;
        @(negedge clk);
        ctl_reset = 1'b0;
    endtask

    function automatic logic [31:0] pw(input int k);
        return pkt_words[32*k +: 32];
    endfunction

    task automatic t_reset_state();
        chk("R8 status after reset", 32'(status), 32'd0);
        chk("R9 no packet after reset", 32'(pkt_valid), 32'd0);
        chk("R5 no pixel after reset", 32'(pix_valid), 32'd0);
        for (int i = 0; i < 8; i++)
            chk("R8 env reload", env_regs[32*i +: 32], {8'hE0 + 8'(i), 24'h0});
    endtask

    // Fixed-length packet: watches for an early strobe, then the final one
    task automatic t_fixed(input logic [7:0] op, input int len);
        logic early;
        early = 1'b0;
        for (int k = 0; k < len; k++) begin
            send(k == 0 ? {op, 24'h000100} : 32'h0003_0003 * k);
            if (k < len - 1 && pkt_valid) early = 1'b1;
        end
        chk("R1 no early strobe", 32'(early), 32'd0);
        chk("R9 strobe", 32'(pkt_valid), 32'd1);
        chk("R1 length", 32'(pkt_count), 32'(len));
        chk("R9 word0", pw(0), {op, 24'h000100});
        chk("R9 last word", pw(len - 1), len == 1 ? {op, 24'h000100} : 32'h0003_0003 * (len - 1));
        @(negedge clk);
        chk("R9 strobe one cycle", 32'(pkt_valid), 32'd0);
    endtask

    task automatic t_env();
        send(32'hE1000123);
        chk("R3 no packet for env", 32'(pkt_valid), 32'd0);
        chk("R3 env1 stored", env_regs[32*1 +: 32], 32'hE1000123);
        chk("R4 status mode bits", 32'(status[10:0]), 32'h123);
        send(32'hE6000003);
        chk("R4 status mask bits", 32'(status[12:11]), 32'd3);
        send(32'hE3ABCDEF);
        chk("R3 env3 stored", env_regs[32*3 +: 32], 32'hE3ABCDEF);
        chk("R3 env1 kept", env_regs[32*1 +: 32], 32'hE1000123);
    endtask

    task automatic t_poly_flat();
        logic early;
        early = 1'b0;
        send(32'h48112233); send(32'h00100010);
        send(32'h50005000); if (pkt_valid) early = 1'b1;   // index 2: not a terminator
        send(32'h00200020); if (pkt_valid) early = 1'b1;
        send(32'h55005500);
        chk("R2 flat no early close", 32'(early), 32'd0);
        chk("R2 flat closes", 32'(pkt_valid), 32'd1);
        chk("R2 flat length", 32'(pkt_count), 32'd5);
        chk("R2 terminator kept", pw(4), 32'h55005500);
    endtask

    task automatic t_poly_shaded();
        logic early;
        early = 1'b0;
        send(32'h58AABBCC); send(32'h00100010); send(32'h00FF00FF);
        send(32'h50005000); if (pkt_valid) early = 1'b1;   // odd index ignored
        send(32'h00300030); if (pkt_valid) early = 1'b1;
        send(32'h5A5A5A5A); if (pkt_valid) early = 1'b1;   // odd index ignored
        send(32'h5FFF5FFF);
        chk("R2 shaded no early close", 32'(early), 32'd0);
        chk("R2 shaded closes", 32'(pkt_valid), 32'd1);
        chk("R2 shaded length", 32'(pkt_count), 32'd7);
    endtask

    task automatic t_poly_full();
        send(32'h48000000);
        for (int k = 1; k < 16; k++) send(32'h00010001);
        chk("R2 forced close", 32'(pkt_valid), 32'd1);
        chk("R2 forced length", 32'(pkt_count), 32'd16);
    endtask

    task automatic t_upload(input logic [31:0] size);
        int wd, ht, nwords;
        logic bad;
        wd = (size[9:0] == 0) ? 1024 : int'(size[9:0]);
        ht = (size[24:16] == 0) ? 512 : int'(size[24:16]);
        nwords = (wd * ht + 1) / 2;
        bad = 1'b0;
        send(32'hA0000000); send(32'h00040008); send(size);
        chk("R5 header packet", 32'(pkt_valid), 32'd1);
        chk("R5 header length", 32'(pkt_count), 32'd3);
        chk("R6 busy set", 32'(status[13]), 32'd1);
        for (int k = 0; k < nwords; k++) begin
            send(32'hC0DE0000 + k);
            if (!pix_valid || pix_word !== 32'hC0DE0000 + k || pkt_valid) bad = 1'b1;
            if (k < nwords - 1 && !status[13]) bad = 1'b1;
        end
        chk("R5 pixel words forwarded", 32'(bad), 32'd0);
        chk("R6 busy cleared", 32'(status[13]), 32'd0);
        send(32'h00000000);
        chk("R5 framing resumes", 32'(pkt_valid), 32'd1);
        chk("R5 not a pixel", 32'(pix_valid), 32'd0);
    endtask

    task automatic t_download_hdr();
        send(32'hC0000000); send(32'h0); send(32'h00020002);
        chk("R5 read header packet", 32'(pkt_count), 32'd3);
        chk("R6 no busy on read header", 32'(status[13]), 32'd0);
    endtask

    task automatic t_pause();
        send(32'h28000001); send(32'h00010001);
        chk("R7 held flag", 32'(status[14]), 32'd1);
        repeat (6) @(negedge clk);
        chk("R7 no packet while paused", 32'(pkt_valid), 32'd0);
        send(32'h00020002); send(32'h00030003); send(32'h00040004);
        chk("R7 completes", 32'(pkt_valid), 32'd1);
        chk("R7 length", 32'(pkt_count), 32'd5);
        chk("R7 word1 kept", pw(1), 32'h00010001);
        chk("R7 held flag cleared", 32'(status[14]), 32'd0);
    endtask

    task automatic t_ctl_reset();
        send(32'hE1000555);
        send(32'h20000000);
        pulse_ctl();
        chk("R8 status cleared", 32'(status), 32'd0);
        chk("R8 env1 reloaded", env_regs[32*1 +: 32], 32'hE1000000);
        send(32'h01000000);
        chk("R8 buffer discarded", 32'(pkt_valid), 32'd1);
        chk("R8 fresh length", 32'(pkt_count), 32'd1);
        send(32'hA0000000); send(32'h0); send(32'h00020002);
        pulse_ctl();
        chk("R8 upload cancelled", 32'(status[13]), 32'd0);
        send(32'h00000000);
        chk("R8 framed after cancel", 32'(pkt_valid), 32'd1);
        chk("R8 no pixel after cancel", 32'(pix_valid), 32'd0);
    endtask

    initial begin
        #3000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_fixed(8'h20, 4);  t_fixed(8'h3C, 12); t_fixed(8'h30, 6);
        t_fixed(8'h2C, 9);  t_fixed(8'h44, 3);  t_fixed(8'h50, 4);
        t_fixed(8'h60, 3);  t_fixed(8'h64, 4);  t_fixed(8'h74, 3);
        t_fixed(8'h02, 3);  t_fixed(8'h80, 4);  t_fixed(8'h00, 1);
        t_env();
        t_poly_flat();
        t_poly_shaded();
        t_poly_full();
        t_upload(32'h00030005);
        t_upload(32'h00010000);
        t_download_hdr();
        t_pause();
        t_ctl_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule